// File: doc/BRIEF.md
# Block-Strided Link DMA Engine

This engine serves one link direction of a node. Each command makes it move a group of equal-length runs of consecutive memory words. The start of each run sits a fixed distance, the stride, past the start of the run before it. The processor issues one command and takes no part in the transfer after that. Each link direction gets its own copy of the engine, so several transfers can run at once.

In send mode the engine reads each word from memory and presents it to the link transmitter. It holds the word until the transmitter takes it. In receive mode it takes each word from the link receiver and writes it to memory. The memory port uses a request and grant. An outside arbiter may keep the grant low for any number of cycles. The engine handles one word at a time, and `done` pulses once after the final word.

Top module: `strided_dma`

## Requirements
- R1: `cmd_ready` is high exactly when the engine is idle. A command is taken only when `cmd_valid` and `cmd_ready` are both high at a clock edge. While the engine is busy, `cmd_valid` has no effect on the words it moves.
- R2: The k-th memory access of a command (k counted from 0) uses address base + b*stride + i, where b = k / len and i = k mod len. Accesses run in k order.
- R3: Addresses are 19 bits wide and are computed modulo 2^19, so a transfer that runs past the top of the space continues from address 0.
- R4: When `cmd_dir` = 0 (send), every access is a read (`mem_we` = 0). The words go out on `tx_data` in access order. Each carries the value that memory held at its address. The `mem_rdata` value is sampled in the cycle after the grant.
- R5: When `cmd_dir` = 1 (receive), every access is a write (`mem_we` = 1). The words taken on `rx_valid && rx_ready` are written in arrival order, one per access.
- R6: Once `mem_req` is high without `mem_gnt`, it stays high in the next cycle. `mem_addr`, `mem_we` and `mem_wdata` do not change until the grant. `tx_valid` and `tx_data` are held in the same way until `tx_ready`.
- R7: `done` is high for one cycle. It rises in the cycle after the last word completes: the last transmit handshake in send mode, or the last write grant in receive mode. `done` is never high at any other time, and the engine is idle when `done` is high.
- R8: A command whose length or count is zero raises `done` in the cycle after it is accepted. Such a command makes no memory request and leaves the engine idle.
- R9: In send mode `rx_ready` stays low. In receive mode `tx_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_dir | input | 1 | 0 = send (memory to link), 1 = receive (link to memory) |
| cmd_base | input | 19 | Address of the first word |
| cmd_len | input | 8 | Words per block |
| cmd_count | input | 8 | Number of blocks |
| cmd_stride | input | 19 | Distance between block starts |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 19 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access granted at this edge |
| mem_rdata | input | 32 | Read data, valid the cycle after a read grant |
| tx_valid | output | 1 | Word offered to link transmitter |
| tx_data | output | 32 | Word for the transmitter |
| tx_ready | input | 1 | Transmitter takes the word |
| rx_valid | input | 1 | Link receiver has a word |
| rx_data | input | 32 | Word from the receiver |
| rx_ready | output | 1 | Engine takes the received word |

## Verification
The address walk is tried in several shapes. A stride larger than the block length shows that the engine steps between blocks. A stride of zero repeats one block. A base just below the top of the space shows where the address wraps. A single-word transfer meets the first and last word in the same access. Zero-length and zero-count commands separate an immediate finish from a hung engine or stray requests. A receive into a region followed by a send from the same region shows that data reaches memory in the right order. Grants, transmitter readiness and receiver validity are dropped at random throughout, which exposes any loss of the held request or held word. A second command is also driven while the engine is busy.

// File: rtl/strided_dma_pkg.sv
// Shared types for the block-strided DMA engine.
package strided_dma_pkg;
    // Sequencer states: idle, read path, receive path.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_DATA,
        ST_TX_HOLD,
        ST_RX_WAIT,
        ST_WR_REQ
    } dma_state_t;
endpackage

// File: rtl/dma_addr_gen.sv
// Address walker: holds the command geometry and yields base + b*stride + i.
// Assumes load is asserted only with a non-zero length and count; step advances
// one word. The sum wraps at 2^ADDR_W.
module dma_addr_gen #(
    parameter int ADDR_W = 19,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] stride,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [ADDR_W-1:0] blk_start, stride_q;
    logic [LEN_W-1:0]  off, len_q;
    logic [CNT_W-1:0]  blk, cnt_q;
    logic              blk_end;

    // Decode end of block and end of transfer.
    always_comb begin
        blk_end = (off == len_q - LEN_W'(1));
        last    = blk_end && (blk == cnt_q - CNT_W'(1));
        addr    = blk_start + ADDR_W'(off);
    end

    // Capture geometry on load, advance word/block counters on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_start <= '0;
            stride_q  <= '0;
            off       <= '0;
            len_q     <= '0;
            blk       <= '0;
            cnt_q     <= '0;
        end else if (load) begin
            blk_start <= base;
            stride_q  <= stride;
            len_q     <= len;
            cnt_q     <= count;
            off       <= '0;
            blk       <= '0;
        end else if (step) begin
            if (blk_end) begin
                off       <= '0;
                blk       <= blk + CNT_W'(1);
                blk_start <= blk_start + stride_q;
            end else begin
                off <= off + LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/dma_seq.sv
// Word sequencer: moves one word at a time between the memory port and the link.
// Assumes a read grant returns data on mem_rdata in the following cycle.
module dma_seq
    import strided_dma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_dir,
    input  logic              cmd_zero,
    output logic              cmd_ready,
    output logic              load,
    output logic              step,
    input  logic              last,
    output logic              mem_req,
    output logic              mem_we,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] word_q,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              done
);
    dma_state_t state;
    logic       accept, finish;

    // Moore outputs and handshake decode.
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        accept    = cmd_ready && cmd_valid;
        load      = accept && !cmd_zero;
        mem_req   = (state == ST_RD_REQ) || (state == ST_WR_REQ);
        mem_we    = (state == ST_WR_REQ);
        tx_valid  = (state == ST_TX_HOLD);
        rx_ready  = (state == ST_RX_WAIT);
        step      = (tx_valid && tx_ready) || (mem_we && mem_gnt);
        finish    = step && last;
    end

    // State transitions, word capture and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            word_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= (accept && cmd_zero) || finish;
            unique case (state)
                ST_IDLE:    if (load) state <= cmd_dir ? ST_RX_WAIT : ST_RD_REQ;
                ST_RD_REQ:  if (mem_gnt) state <= ST_RD_DATA;
                ST_RD_DATA: begin
                    word_q <= mem_rdata;
                    state  <= ST_TX_HOLD;
                end
                ST_TX_HOLD: if (tx_ready) state <= last ? ST_IDLE : ST_RD_REQ;
                ST_RX_WAIT: if (rx_valid) begin
                    word_q <= rx_data;
                    state  <= ST_WR_REQ;
                end
                ST_WR_REQ:  if (mem_gnt) state <= last ? ST_IDLE : ST_RX_WAIT;
                default:    state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/strided_dma.sv
// Block-strided DMA engine for one link direction: one command moves count
// blocks of len contiguous words, block starts stride apart, in either direction.
module strided_dma #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_dir,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [ADDR_W-1:0] cmd_stride,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready
);
    logic load, step, last, cmd_zero;
    logic [DATA_W-1:0] word_q;

    // An empty geometry finishes without a walk.
    always_comb cmd_zero = (cmd_len == '0) || (cmd_count == '0);

    // The one held word serves as transmit and write data.
    always_comb begin
        tx_data   = word_q;
        mem_wdata = word_q;
    end

    dma_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_agen (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .base(cmd_base), .len(cmd_len), .count(cmd_count), .stride(cmd_stride),
        .addr(mem_addr), .last(last)
    );

    dma_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dir(cmd_dir),
        .cmd_zero(cmd_zero), .cmd_ready(cmd_ready), .load(load), .step(step),
        .last(last), .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .word_q(word_q), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .done(done)
    );
endmodule

// File: rtl/strided_dma_chk.sv
// Port-level protocol checker for strided_dma, attached by bind.
module strided_dma_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [LEN_W-1:0]  cmd_len,
    input logic [CNT_W-1:0]  cmd_count,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_gnt,
    input logic              tx_valid,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_ready,
    input logic              rx_ready
);
    // R6: a waiting request keeps address, kind and data.
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    // R6: an offered transmit word is held until taken.
    a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
    // R1: an accepted non-empty command makes the engine busy.
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_len != '0 && cmd_count != '0 |=> !cmd_ready);
    // R1: an idle engine issues nothing.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_req && !tx_valid && !rx_ready);
    // R7: done only while idle.
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);
    // R8: empty command finishes next cycle with no request.
    a_r8_empty_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && (cmd_len == '0 || cmd_count == '0) |=> done && !mem_req && cmd_ready);
    // R9: transmit and receive sides never active together.
    a_r9_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({tx_valid, rx_ready}) <= 1);
endmodule

bind strided_dma strided_dma_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_len(cmd_len), .cmd_count(cmd_count), .done(done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .rx_ready(rx_ready)
);

// File: tb/sim_strided_dma.sv
// Bench: behavioural model of the address walk and data order, compared each clock.
module sim_strided_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_dir = 1'b0;
    logic [18:0] cmd_base = '0, cmd_stride = '0;
    logic [7:0]  cmd_len = '0, cmd_count = '0;
    logic        cmd_ready, done, mem_req, mem_we, tx_valid, rx_ready;
    logic [18:0] mem_addr;
    logic [31:0] mem_wdata, tx_data;
    logic        mem_gnt = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0;
    logic [31:0] mem_rdata = '0, rx_data = 32'h1000_0000;

    always #10 clk = ~clk;   // 50 MHz

    strided_dma u0 (.*);

    int n_cmp = 0, n_bad = 0, cyc = 0, n_done = 0;
    logic [31:0] store [int];
    int          exp_addr [$];
    int          rd_addr [$];
    logic [31:0] wr_data [$];
    bit busy = 0, dir_m = 0, done_exp = 0, accepted = 0, rx_taken = 0;
    bit pend = 0, pend_we = 0;
    logic [18:0] pend_addr;
    logic [31:0] pend_wd;
    string tag = "R2";

    function automatic logic [31:0] memval(int a);
        if (store.exists(a)) return store[a];
        return 32'hA5A5_0000 ^ (a * 7);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Synchronous memory model.
    always @(posedge clk) begin
        if (mem_req && mem_gnt) begin
            if (mem_we) store[int'(mem_addr)] = mem_wdata;
            else mem_rdata <= memval(int'(mem_addr));
        end
    end

    // Stimulus and per-clock comparison.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(0, "watchdog", 0, 1);
            summary();
        end
        mem_gnt  = ($urandom % 4) != 0;
        tx_ready = ($urandom % 3) != 0;
        if (rx_taken) rx_data = rx_data + 32'h0001_0003;
        rx_taken = 0;
        rx_valid = ($urandom % 3) != 0;
        #1;
        if (rst_n) begin
            chk(done == done_exp, "R7", {31'd0, done}, {31'd0, done_exp});
            if (done) n_done++;
            done_exp = 0;
            chk(cmd_ready == !busy, "R1", {31'd0, cmd_ready}, {31'd0, !busy});
            if (busy && !dir_m) chk(!rx_ready, "R9", {31'd0, rx_ready}, 0);
            if (busy && dir_m)  chk(!tx_valid, "R9", {31'd0, tx_valid}, 0);
            if (pend) chk(mem_req && mem_addr == pend_addr && mem_we == pend_we &&
                          (!pend_we || mem_wdata == pend_wd), "R6", {13'd0, mem_addr}, {13'd0, pend_addr});
            pend = mem_req && !mem_gnt;
            pend_addr = mem_addr; pend_we = mem_we; pend_wd = mem_wdata;
            if (cmd_valid && cmd_ready) begin
                accepted = 1;
                dir_m = cmd_dir;
                if (cmd_len == 0 || cmd_count == 0) done_exp = 1;
                else begin
                    busy = 1;
                    for (int b = 0; b < int'(cmd_count); b++)
                        for (int i = 0; i < int'(cmd_len); i++)
                            exp_addr.push_back((int'(cmd_base) + b * int'(cmd_stride) + i) & 32'h7FFFF);
                end
            end
            if (mem_req && mem_gnt) begin
                if (exp_addr.size() == 0) chk(0, "R8", {13'd0, mem_addr}, 0);
                else begin
                    int a;
                    a = exp_addr.pop_front();
                    chk(mem_addr == 19'(a), tag, {13'd0, mem_addr}, a);
                    chk(mem_we == dir_m, dir_m ? "R5" : "R4", {31'd0, mem_we}, {31'd0, dir_m});
                    if (mem_we) begin
                        logic [31:0] w;
                        w = (wr_data.size() != 0) ? wr_data.pop_front() : 32'hDEAD_BEEF;
                        chk(mem_wdata == w, "R5", mem_wdata, w);
                        if (exp_addr.size() == 0) begin done_exp = 1; busy = 0; end
                    end else rd_addr.push_back(a);
                end
            end
            if (tx_valid && tx_ready) begin
                if (rd_addr.size() == 0) chk(0, "R4", tx_data, 0);
                else begin
                    int a;
                    a = rd_addr.pop_front();
                    chk(tx_data == memval(a), "R4", tx_data, memval(a));
                    if (exp_addr.size() == 0 && rd_addr.size() == 0) begin done_exp = 1; busy = 0; end
                end
            end
            if (rx_valid && rx_ready) begin
                wr_data.push_back(rx_data);
                rx_taken = 1;
            end
        end
    end

    // Issue one command; optionally drive a stray command while busy; wait for done.
    task automatic run(bit dir, int base, int len, int cnt, int stride, string t, bit poke);
        int d0;
        d0 = n_done;
        tag = t;
        @(negedge clk);
        cmd_valid = 1; cmd_dir = dir; cmd_base = 19'(base);
        cmd_len = 8'(len); cmd_count = 8'(cnt); cmd_stride = 19'(stride);
        accepted = 0;
        while (!accepted) @(negedge clk);
        if (poke) begin
            cmd_dir = !dir; cmd_base = 19'h3_0000; cmd_len = 8'd2; cmd_count = 8'd2;
            repeat (6) @(negedge clk);
        end
        cmd_valid = 0;
        while (n_done == d0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cmd_ready && !mem_req && !tx_valid && !rx_ready && !done, "R1 reset",
            {27'd0, cmd_ready, mem_req, tx_valid, rx_ready, done}, 32'h10);
        rst_n = 1;
        run(0, 32'h100, 4, 3, 16, "R2", 0);            // send, stride beyond block
        run(1, 32'h2000, 3, 4, 5, "R2", 0);            // receive, gap between blocks
        run(0, 32'h2000, 3, 4, 5, "R5", 0);            // read back received words
        run(0, 32'h7FFFA, 4, 3, 8, "R3", 0);           // wrap at the top of the space
        run(1, 32'h7FFFE, 5, 1, 0, "R3", 0);           // receive across the top
        run(0, 32'h500, 0, 3, 4, "R8", 0);             // zero length
        run(1, 32'h500, 4, 0, 4, "R8", 0);             // zero count
        run(0, 32'h42, 1, 1, 0, "R2", 0);              // single word
        run(1, 32'h800, 3, 3, 0, "R2", 0);             // stride zero repeats a block
        run(0, 32'h800, 3, 1, 0, "R5", 0);             // last writer wins
        run(0, 32'h1234, 4, 3, 32, "R1", 1);           // stray command while busy
        run(1, 32'h4000, 8, 6, 100, "R2", 0);          // longer receive
        summary();
    end
endmodule